// File: doc/BRIEF.md
# Video Line and Slot Counter

This block keeps the raster position for a video timing generator. A slot is one memory access window, two processor clock ticks long. Each slot the block is told to advance, it moves a horizontal slot counter. When a line ends, the slot counter returns to zero and the line counter steps. When the last line of a field ends, the line counter returns to zero. Downstream logic uses the two counters, a field-parity flag, and two decoded strobes to schedule fetches and sync.

Two television standards are supported, chosen by one input. In the 60 Hz standard, lines alternate between a short length of 227 slots and a long length of 228. A field has 262 lines. In the 50 Hz standard, every line is 227 slots and a field has 312 lines. With interlace on, one field in two gets an extra line, giving 263 or 313 lines. The standard and interlace inputs are sampled only at frame boundaries, so a frame never mixes two geometries.

Top module: `vlsc_top`

## Requirements
- R1: While reset is held and on the first cycle after it, the slot and line counters are 0, the field flag is 0, both strobes are 1, and the first line is a short one. Reset also samples the standard and interlace inputs.
- R2: In the 60 Hz standard (std_sel = 0), line lengths alternate 227, 228, 227 and so on. The first line after reset is 227 slots. The short/long choice flips at every line end, including across frame boundaries.
- R3: In the 50 Hz standard (std_sel = 1), every line is 227 slots. The slot counter never exceeds line length minus one.
- R4: Without interlace, a 60 Hz field has 262 lines (numbered 0 to 261) and a 50 Hz field has 312 lines.
- R5: With interlace active, field_odd inverts at each frame end. A field with field_odd = 1 has one extra line (263 at 60 Hz, 313 at 50 Hz). A field with field_odd = 0 has the base count.
- R6: While interlace is not active for the current frame, field_odd is 0. The flag is cleared at the first frame boundary after interlace is turned off.
- R7: std_sel and interlace_en are sampled only in the cycle where the last slot of the last line advances, and during reset. Changes at any other time have no effect on the counters or field_odd until that boundary.
- R8: While slot_en is 0, slot_pos, line_num, field_odd and both strobes hold their values.
- R9: line_start is 1 exactly when slot_pos is 0. frame_start is 1 exactly when slot_pos and line_num are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Advance by one slot this cycle |
| std_sel | input | 1 | 0 selects 60 Hz geometry, 1 selects 50 Hz |
| interlace_en | input | 1 | Request interlaced field alternation |
| slot_pos | output | SLOT_W | Slot position within the line |
| line_num | output | LINE_W | Line number within the field |
| field_odd | output | 1 | Field parity; 1 marks the long field |
| line_start | output | 1 | Counter sits on slot 0 |
| frame_start | output | 1 | Counter sits on slot 0 of line 0 |

## Verification
The bench drives a reduced-geometry instance through a long sequence of stalls and mid-frame changes to standard and interlace. It compares every cycle against an arithmetic model. This exposes a design that applies new settings at once and produces a hybrid frame. It also exposes a design that resets the short/long phase at each frame, breaking the alternation across the boundary. A third fault it catches is a field flag that keeps toggling after interlace is dropped, which would leave stray long fields.

A full-size instance is timed over one 60 Hz frame and one 50 Hz frame, checking the 227/228 first-line lengths and total frame lengths of 59,605 and 70,824 slots. An off-by-one in a wrap compare shows up as a wrong line length or line count.

// File: rtl/vlsc_pkg.sv
package vlsc_pkg;

    typedef enum logic {
        STD_60HZ = 1'b0,
        STD_50HZ = 1'b1
    } vstd_e;

    typedef struct packed {
        vstd_e std;
        logic  lace;
    } vcfg_t;

    // Slots in the current line for a given geometry and phase
    function automatic int unsigned pick_line_len(
        input vstd_e       s,
        input logic        long_phase,
        input int unsigned len_short,
        input int unsigned len_long,
        input int unsigned len_50
    );
        if (s == STD_50HZ)
            return len_50;
        return long_phase ? len_long : len_short;
    endfunction

    // Lines in the current field; the odd interlaced field adds one
    function automatic int unsigned pick_frame_len(
        input vstd_e       s,
        input logic        extra_line,
        input int unsigned lines_60,
        input int unsigned lines_50
    );
        int unsigned base;
        base = (s == STD_50HZ) ? lines_50 : lines_60;
        return base + (extra_line ? 1 : 0);
    endfunction

endpackage

// File: rtl/vlsc_slot_ctr.sv
module vlsc_slot_ctr #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [SLOT_W-1:0] len,
    output logic [SLOT_W-1:0] pos,
    output logic              wrap
);
    logic [SLOT_W-1:0] last_pos;

    assign last_pos = len - 1'b1;
    assign wrap     = adv && (pos == last_pos);

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (wrap)
            pos <= '0;
        else if (adv)
            pos <= pos + 1'b1;
    end
endmodule

// File: rtl/vlsc_line_ctr.sv
module vlsc_line_ctr #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [LINE_W-1:0] len,
    output logic [LINE_W-1:0] num,
    output logic              wrap
);
    logic [LINE_W-1:0] last_line;

    assign last_line = len - 1'b1;
    assign wrap      = adv && (num == last_line);

    always_ff @(posedge clk) begin
        if (rst)
            num <= '0;
        else if (wrap)
            num <= '0;
        else if (adv)
            num <= num + 1'b1;
    end
endmodule

// File: rtl/vlsc_cfg_reg.sv
module vlsc_cfg_reg
    import vlsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_end,
    input  logic  std_in,
    input  logic  lace_in,
    output vcfg_t cfg,
    output logic  field_odd
);
    vcfg_t sampled;

    always_comb begin
        sampled.std  = vstd_e'(std_in);
        sampled.lace = lace_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= sampled;
            field_odd <= 1'b0;
        end else if (frame_end) begin
            cfg       <= sampled;
            field_odd <= lace_in ? ~field_odd : 1'b0;
        end
    end
endmodule

// File: rtl/vlsc_top.sv
module vlsc_top
    import vlsc_pkg::*;
#(
    parameter int SLOT_W    = 8,
    parameter int LINE_W    = 9,
    parameter int LEN_SHORT = 227,
    parameter int LEN_LONG  = 228,
    parameter int LEN_50    = 227,
    parameter int LINES_60  = 262,
    parameter int LINES_50  = 312
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_en,
    input  logic              std_sel,
    input  logic              interlace_en,
    output logic [SLOT_W-1:0] slot_pos,
    output logic [LINE_W-1:0] line_num,
    output logic              field_odd,
    output logic              line_start,
    output logic              frame_start
);
    vcfg_t             cfg_q;
    logic              long_phase;
    logic              line_end;
    logic              frame_end;
    logic [SLOT_W-1:0] cur_line_len;
    logic [LINE_W-1:0] cur_frame_len;

    always_comb begin
        cur_line_len  = SLOT_W'(pick_line_len(cfg_q.std, long_phase,
                                              LEN_SHORT, LEN_LONG, LEN_50));
        cur_frame_len = LINE_W'(pick_frame_len(cfg_q.std, field_odd,
                                               LINES_60, LINES_50));
    end

    // Short/long alternation runs freely across frames
    always_ff @(posedge clk) begin
        if (rst)
            long_phase <= 1'b0;
        else if (line_end)
            long_phase <= ~long_phase;
    end

    vlsc_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .adv  (slot_en),
        .len  (cur_line_len),
        .pos  (slot_pos),
        .wrap (line_end)
    );

    vlsc_line_ctr #(.LINE_W(LINE_W)) u_line (
        .clk  (clk),
        .rst  (rst),
        .adv  (line_end),
        .len  (cur_frame_len),
        .num  (line_num),
        .wrap (frame_end)
    );

    vlsc_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .std_in    (std_sel),
        .lace_in   (interlace_en),
        .cfg       (cfg_q),
        .field_odd (field_odd)
    );

    assign line_start  = (slot_pos == '0);
    assign frame_start = line_start && (line_num == '0);
endmodule

// File: rtl/vlsc_checker.sv
module vlsc_checker #(
    parameter int SLOT_W    = 8,
    parameter int LINE_W    = 9,
    parameter int LEN_LONG  = 228,
    parameter int LEN_50    = 227,
    parameter int LINES_50  = 312
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_en,
    input logic [SLOT_W-1:0] slot_pos,
    input logic [LINE_W-1:0] line_num,
    input logic              field_odd,
    input logic              line_start,
    input logic              frame_start,
    input logic              lace_active,
    input logic [1:0]        cfg_bits
);
    localparam int MAX_SLOT = (LEN_LONG > LEN_50) ? LEN_LONG : LEN_50;

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> ($stable(slot_pos) && $stable(line_num) && $stable(field_odd)));

    p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
        slot_en |=> ((slot_pos == $past(slot_pos) + 1'b1) || (slot_pos == '0)));

    p_line_step_r4: assert property (@(posedge clk) disable iff (rst)
        slot_en |=> ((slot_pos != '0) ? (line_num == $past(line_num))
                     : ((line_num == $past(line_num) + 1'b1) || (line_num == '0))));

    p_slot_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (32'(slot_pos) < MAX_SLOT));

    p_line_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(line_num) <= LINES_50));

    p_field_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !lace_active |-> !field_odd);

    p_cfg_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bits) |-> frame_start);

    p_field_boundary_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_odd) |-> frame_start);

    p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (line_start && (line_num == '0)));
endmodule

bind vlsc_top vlsc_checker #(
    .SLOT_W   (SLOT_W),
    .LINE_W   (LINE_W),
    .LEN_LONG (LEN_LONG),
    .LEN_50   (LEN_50),
    .LINES_50 (LINES_50)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_en     (slot_en),
    .slot_pos    (slot_pos),
    .line_num    (line_num),
    .field_odd   (field_odd),
    .line_start  (line_start),
    .frame_start (frame_start),
    .lace_active (cfg_q.lace),
    .cfg_bits    (cfg_q)
);

// File: tb/tb_vlsc_top.sv
module tb_vlsc_top;
    localparam int S_SHORT = 5;
    localparam int S_LONG  = 6;
    localparam int S_L50   = 4;
    localparam int S_F60   = 4;
    localparam int S_F50   = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // full-size instance
    logic       rst_f = 1'b1, en_f = 1'b0, std_f = 1'b0, lace_f = 1'b0;
    logic [7:0] slot_f;
    logic [8:0] line_f;
    logic       fld_f, ls_f, fs_f;

    vlsc_top dut (
        .clk(clk), .rst(rst_f), .slot_en(en_f), .std_sel(std_f),
        .interlace_en(lace_f), .slot_pos(slot_f), .line_num(line_f),
        .field_odd(fld_f), .line_start(ls_f), .frame_start(fs_f)
    );

    // reduced-geometry instance
    logic       rst_s = 1'b1, en_s = 1'b0, std_s = 1'b0, lace_s = 1'b0;
    logic [7:0] slot_s;
    logic [8:0] line_s;
    logic       fld_s, ls_s, fs_s;

    vlsc_top #(
        .LEN_SHORT(S_SHORT), .LEN_LONG(S_LONG), .LEN_50(S_L50),
        .LINES_60(S_F60), .LINES_50(S_F50)
    ) dut_s (
        .clk(clk), .rst(rst_s), .slot_en(en_s), .std_sel(std_s),
        .interlace_en(lace_s), .slot_pos(slot_s), .line_num(line_s),
        .field_odd(fld_s), .line_start(ls_s), .frame_start(fs_s)
    );

    // arithmetic model of the reduced instance
    int m_slot, m_line;
    bit m_long, m_field, m_std, m_lace;

    always @(posedge clk) begin
        int len, flen;
        if (rst_s) begin
            m_slot = 0; m_line = 0; m_long = 0; m_field = 0;
            m_std = std_s; m_lace = lace_s;
        end else if (en_s) begin
            len  = m_std ? S_L50 : (m_long ? S_LONG : S_SHORT);
            flen = (m_std ? S_F50 : S_F60) + (m_field ? 1 : 0);
            if (m_slot == len - 1) begin
                m_slot = 0;
                m_long = !m_long;
                if (m_line == flen - 1) begin
                    m_line  = 0;
                    m_std   = std_s;
                    m_lace  = lace_s;
                    m_field = lace_s ? !m_field : 1'b0;
                end else begin
                    m_line = m_line + 1;
                end
            end else begin
                m_slot = m_slot + 1;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_small();
        check("R2 R3 R7 R8 slot_pos", int'(slot_s), m_slot);
        check("R4 R5 R7 R8 line_num", int'(line_s), m_line);
        check("R5 R6 R7 field_odd", int'(fld_s), int'(m_field));
        check("R9 line_start", int'(ls_s), int'(m_slot == 0));
        check("R9 frame_start", int'(fs_s), int'(m_slot == 0 && m_line == 0));
    endtask

    task automatic time_frame(input bit switch_std, output int flen,
                              output int len0, output int len1, output int maxl);
        int n = 0;
        int prev = 0;
        maxl = 0; len0 = 0; len1 = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 10 && switch_std) std_f = 1'b1;
            if (int'(line_f) > maxl) maxl = int'(line_f);
            if (line_f == 9'd1 && len0 == 0 && ls_f) begin len0 = n; prev = n; end
            if (line_f == 9'd2 && len1 == 0 && ls_f) len1 = n - prev;
        end while (!fs_f);
        flen = n;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int flen, l0, l1, mx;
        bit [15:0] lfsr = 16'hACE1;

        // R1 reset state, reduced instance with 50 Hz sampled at reset
        std_s = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset slot", int'(slot_s), 0);
        check("R1 reset line", int'(line_s), 0);
        check("R1 reset field", int'(fld_s), 0);
        check("R1 reset strobes", int'(ls_s && fs_s), 1);
        std_s = 1'b0;  // R7: reset already sampled 50 Hz
        rst_s = 1'b0;
        en_s  = 1'b1;

        // sweep with stalls and mid-frame config changes
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare_small();
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            en_s = (lfsr[2:0] != 3'b000);
            if (i % 97 == 13)  std_s  = !std_s;
            if (i % 151 == 40) lace_s = !lace_s;
            if (i == 3000) begin lace_s = 1'b1; std_s = 1'b0; end
        end
        en_s = 1'b0;

        // full size: reset into 60 Hz non-interlaced
        std_f = 1'b0; lace_f = 1'b0; en_f = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 full reset slot", int'(slot_f), 0);
        rst_f = 1'b0;
        time_frame(1'b1, flen, l0, l1, mx);
        check("R2 first 60 Hz line", l0, 227);
        check("R2 second 60 Hz line", l1, 228);
        check("R4 60 Hz frame slots", flen, 59605);
        check("R4 60 Hz last line", mx, 261);
        // std switched mid-frame now applies (R7)
        time_frame(1'b0, flen, l0, l1, mx);
        check("R3 50 Hz line 0", l0, 227);
        check("R3 50 Hz line 1", l1, 227);
        check("R4 R7 50 Hz frame slots", flen, 70824);
        check("R4 50 Hz last line", mx, 311);
        check("R6 field stays 0", int'(fld_f), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule